// File: doc/BRIEF.md
# DRAM Periodic Refresh Scheduler

This block decides when one DDR SDRAM rank gets an auto-refresh. An interval timer adds one owed refresh to a debt counter every average refresh period. The memory controller's command sequencer sees a refresh request and answers with a one-cycle grant when it issues the REFRESH command. While traffic is pending, owed refreshes are deferred. When the rank is quiet, they are paid back early. Once the debt reaches its limit of eight, refresh overrides all traffic until the debt drops. Before any refresh or self-refresh entry, the scheduler asks the sequencer to close every bank with a precharge-all request.

The block also owns the rank's clock-enable level for self-refresh. A level request puts the rank into self-refresh once all banks are idle. During self-refresh the interval timer holds its position and the debt is wiped, because the device refreshes itself. When the request drops, clock enable returns high and two exit guards start. The guard for non-read commands lasts 10 cycles. The guard for reads lasts 200 cycles.

Three permission outputs tell the sequencer what it may issue in the current cycle:
- The non-read permission, which also covers ACTIVATE, is low during the post-refresh busy time and the non-read exit guard.
- The read permission is low during the post-refresh busy time and the read exit guard.
- Both are low while a forced refresh is pending.

Top module: `refresh_sched`

## Requirements
- R1: After reset, debt_o is 0, rf_req_o, pre_all_req_o and urgent_o are 0, and cke_o, act_ok_o and rd_ok_o are 1.
- R2: Outside self-refresh, debt_o rises by one every REFI_CYC clock cycles, the first step occurring REFI_CYC cycles after reset is released.
- R3: With a nonzero debt below MAX_DEBT, rf_req_o is 1 when busy_i is 0, all bank_open_i bits are 0 and no guard is active. It is 0 while busy_i is 1.
- R4: When debt_o equals MAX_DEBT, urgent_o is 1, rf_req_o is 1 even with busy_i high (banks closed), and act_ok_o and rd_ok_o are 0.
- R5: A cycle with rf_gnt_i and rf_req_o both high lowers debt_o by one. A grant while rf_req_o is 0 leaves debt_o unchanged.
- R6: For RFC_CYC cycles after a granted refresh, act_ok_o, rd_ok_o and rf_req_o are 0.
- R7: When a refresh is wanted and any bank_open_i bit is 1, pre_all_req_o is 1 and rf_req_o is 0.
- R8: With sr_req_i high and all banks closed, cke_o goes to 0 at the next edge and debt_o becomes 0. With a bank open, pre_all_req_o is 1 and cke_o stays 1.
- R9: While cke_o is 0, debt_o stays 0 and rf_req_o, act_ok_o and rd_ok_o are 0, for any duration.
- R10: When sr_req_i falls during self-refresh, cke_o returns to 1 at the next edge. act_ok_o then stays 0 for XSNR_CYC cycles and rd_ok_o stays 0 for XSRD_CYC cycles.
- R11: debt_o never exceeds MAX_DEBT; an interval expiring with a full debt and no grant leaves it at MAX_DEBT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Traffic is pending; defer non-forced refreshes |
| bank_open_i | input | NBANK | One bit per bank, 1 when the bank holds an open row |
| sr_req_i | input | 1 | Level request to stay in self-refresh |
| rf_gnt_i | input | 1 | Sequencer issued REFRESH this cycle |
| rf_req_o | output | 1 | Auto-refresh request to the sequencer |
| pre_all_req_o | output | 1 | Request to precharge all banks |
| urgent_o | output | 1 | Debt is full; refresh is forced |
| cke_o | output | 1 | Clock-enable level for the rank (0 in self-refresh) |
| act_ok_o | output | 1 | Non-read commands (ACTIVATE included) permitted |
| rd_ok_o | output | 1 | Read commands permitted |
| debt_o | output | $clog2(MAX_DEBT+1) | Number of refreshes owed |

## Verification
The assertions check properties that must hold on every cycle:
- the debt ceiling;
- that the refresh and precharge-all requests never appear together;
- the permission blackout after a grant or a self-refresh exit;
- the silence of requests during self-refresh;
- that a grant never lets the debt grow.

Some behaviour can only be shown by the bench's scenarios, because it depends on exact cycle counts or on event ordering:
- the exact cycle on which the debt first steps;
- the deferral pattern across busy and open-bank combinations;
- the ignored stray grant;
- saturation after one more interval;
- the exact lengths of the 10-cycle and 200-cycle exit guards.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [0:0] {
        PH_RUN = 1'b0,
        PH_SR  = 1'b1
    } phase_t;

    typedef struct packed {
        logic rf;
        logic pre_all;
        logic sr_go;
        logic sr_leave;
    } sched_dec_t;

    function automatic int unsigned cnt_w(input int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int unsigned REFI_CYC = 1040
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned TW = rfsh_pkg::cnt_w(REFI_CYC - 1);
    localparam logic [TW-1:0] LAST = TW'(REFI_CYC - 1);

    logic [TW-1:0] pos_q;

    assign tick = run && (pos_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (run) begin
            if (pos_q == LAST) pos_q <= '0;
            else               pos_q <= pos_q + 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_debt_ctr.sv
module rfsh_debt_ctr #(
    parameter int unsigned MAX_DEBT = 8,
    localparam int unsigned DW = rfsh_pkg::cnt_w(MAX_DEBT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    input  logic          clr,
    output logic [DW-1:0] debt,
    output logic          full,
    output logic          owed
);
    localparam logic [DW-1:0] FULLV = DW'(MAX_DEBT);

    logic [DW-1:0] debt_q;

    assign debt = debt_q;
    assign full = (debt_q == FULLV);
    assign owed = (debt_q != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            debt_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (!full) debt_q <= debt_q + 1'b1;
                2'b01:   if (owed)  debt_q <= debt_q - 1'b1;
                default: debt_q <= debt_q;
            endcase
        end
    end
endmodule

// File: rtl/rfsh_guard_cnt.sv
module rfsh_guard_cnt #(
    parameter int unsigned LEN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic active
);
    localparam int unsigned GW = rfsh_pkg::cnt_w(LEN);

    logic [GW-1:0] left_q;

    assign active = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst)         left_q <= '0;
        else if (load)   left_q <= GW'(LEN);
        else if (active) left_q <= left_q - 1'b1;
    end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int unsigned NBANK    = 4,
    parameter int unsigned REFI_CYC = 1040,
    parameter int unsigned RFC_CYC  = 10,
    parameter int unsigned XSNR_CYC = 10,
    parameter int unsigned XSRD_CYC = 200,
    parameter int unsigned MAX_DEBT = 8,
    localparam int unsigned DW = rfsh_pkg::cnt_w(MAX_DEBT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy_i,
    input  logic [NBANK-1:0] bank_open_i,
    input  logic             sr_req_i,
    input  logic             rf_gnt_i,
    output logic             rf_req_o,
    output logic             pre_all_req_o,
    output logic             urgent_o,
    output logic             cke_o,
    output logic             act_ok_o,
    output logic             rd_ok_o,
    output logic [DW-1:0]    debt_o
);
    import rfsh_pkg::*;

    phase_t     phase_q;
    sched_dec_t dec;
    logic       run, tick, full, owed, any_open;
    logic       rfc_busy, xsnr_busy, xsrd_busy, granted, want_rf, quiet;

    assign run      = (phase_q == PH_RUN);
    assign any_open = |bank_open_i;
    assign quiet    = !rfc_busy && !xsnr_busy;
    assign want_rf  = run && owed && (full || !busy_i);

    always_comb begin
        dec          = '0;
        dec.sr_go    = run && sr_req_i && !any_open && quiet;
        dec.sr_leave = !run && !sr_req_i;
        dec.rf       = want_rf && !any_open && quiet && !dec.sr_go;
        dec.pre_all  = run && (want_rf || sr_req_i) && any_open && quiet;
    end

    assign granted = dec.rf && rf_gnt_i;

    rfsh_interval_timer #(.REFI_CYC(REFI_CYC)) u_timer (
        .clk (clk),
        .rst (rst),
        .run (run),
        .tick(tick)
    );

    rfsh_debt_ctr #(.MAX_DEBT(MAX_DEBT)) u_debt (
        .clk (clk),
        .rst (rst),
        .inc (tick),
        .dec (granted),
        .clr (dec.sr_go || !run),
        .debt(debt_o),
        .full(full),
        .owed(owed)
    );

    rfsh_guard_cnt #(.LEN(RFC_CYC)) u_rfc (
        .clk(clk), .rst(rst), .load(granted), .active(rfc_busy)
    );

    rfsh_guard_cnt #(.LEN(XSNR_CYC)) u_xsnr (
        .clk(clk), .rst(rst), .load(dec.sr_leave), .active(xsnr_busy)
    );

    rfsh_guard_cnt #(.LEN(XSRD_CYC)) u_xsrd (
        .clk(clk), .rst(rst), .load(dec.sr_leave), .active(xsrd_busy)
    );

    always_ff @(posedge clk) begin
        if (rst)               phase_q <= PH_RUN;
        else if (dec.sr_go)    phase_q <= PH_SR;
        else if (dec.sr_leave) phase_q <= PH_RUN;
    end

    assign rf_req_o      = dec.rf;
    assign pre_all_req_o = dec.pre_all;
    assign urgent_o      = run && full;
    assign cke_o         = run;
    assign act_ok_o      = run && !full && !rfc_busy && !xsnr_busy;
    assign rd_ok_o       = run && !full && !rfc_busy && !xsrd_busy;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int unsigned MAX_DEBT = 8,
    parameter int unsigned DW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          rf_gnt_i,
    input logic          rf_req_o,
    input logic          pre_all_req_o,
    input logic          urgent_o,
    input logic          cke_o,
    input logic          act_ok_o,
    input logic          rd_ok_o,
    input logic [DW-1:0] debt_o
);
    assert_debt_ceiling_R11: assert property (@(posedge clk) disable iff (rst)
        debt_o <= DW'(MAX_DEBT));

    assert_urgent_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        urgent_o |-> (!act_ok_o && !rd_ok_o));

    assert_grant_no_growth_R5: assert property (@(posedge clk) disable iff (rst)
        (rf_req_o && rf_gnt_i) |=> (debt_o <= $past(debt_o)));

    assert_rfc_blackout_R6: assert property (@(posedge clk) disable iff (rst)
        (rf_req_o && rf_gnt_i) |=> (!act_ok_o && !rd_ok_o && !rf_req_o));

    assert_req_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(rf_req_o && pre_all_req_o));

    assert_sr_silent_R9: assert property (@(posedge clk) disable iff (rst)
        !cke_o |-> (debt_o == '0 && !rf_req_o && !act_ok_o && !rd_ok_o));

    assert_exit_guard_R10: assert property (@(posedge clk) disable iff (rst)
        (cke_o && !$past(cke_o)) |-> (!act_ok_o && !rd_ok_o));
endmodule

bind refresh_sched refresh_sched_chk #(.MAX_DEBT(MAX_DEBT), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rf_gnt_i     (rf_gnt_i),
    .rf_req_o     (rf_req_o),
    .pre_all_req_o(pre_all_req_o),
    .urgent_o     (urgent_o),
    .cke_o        (cke_o),
    .act_ok_o     (act_ok_o),
    .rd_ok_o      (rd_ok_o),
    .debt_o       (debt_o)
);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
    localparam int unsigned NB   = 4;
    localparam int unsigned REFI = 64;
    localparam int unsigned RFC  = 10;
    localparam int unsigned XSNR = 10;
    localparam int unsigned XSRD = 200;
    localparam int unsigned MAXD = 8;
    localparam int unsigned DW   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic busy = 1'b1;
    logic [NB-1:0] open_b = '0;
    logic sr_req = 1'b0;
    logic gnt = 1'b0;
    logic rf_req, pre_all, urgent, cke, act_ok, rd_ok;
    logic [DW-1:0] debt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    refresh_sched #(
        .NBANK(NB), .REFI_CYC(REFI), .RFC_CYC(RFC),
        .XSNR_CYC(XSNR), .XSRD_CYC(XSRD), .MAX_DEBT(MAXD)
    ) u_dut (
        .clk(clk), .rst(rst), .busy_i(busy), .bank_open_i(open_b),
        .sr_req_i(sr_req), .rf_gnt_i(gnt), .rf_req_o(rf_req),
        .pre_all_req_o(pre_all), .urgent_o(urgent), .cke_o(cke),
        .act_ok_o(act_ok), .rd_ok_o(rd_ok), .debt_o(debt)
    );

    // fields: busy, open[3:0], expected rf_req, pre_all, act_ok (debt == 1)
    localparam logic [7:0] VEC [6] = '{
        {1'b0, 4'b0000, 1'b1, 1'b0, 1'b1},
        {1'b1, 4'b0000, 1'b0, 1'b0, 1'b1},
        {1'b0, 4'b0010, 1'b0, 1'b1, 1'b1},
        {1'b1, 4'b1000, 1'b0, 1'b0, 1'b1},
        {1'b0, 4'b1111, 1'b0, 1'b1, 1'b1},
        {1'b0, 4'b0001, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(4);
        // R1 reset state
        chk("R1 debt", int'(debt), 0);
        chk("R1 rf_req", int'(rf_req), 0);
        chk("R1 urgent", int'(urgent), 0);
        chk("R1 cke", int'(cke), 1);
        chk("R1 act_ok", int'(act_ok), 1);
        chk("R1 rd_ok", int'(rd_ok), 1);
        rst = 1'b0;
        // R2 first step exactly REFI cycles after release
        step(REFI - 1);
        chk("R2 debt before interval", int'(debt), 0);
        step(1);
        chk("R2 debt after interval", int'(debt), 1);
        // R3 / R7 vector walk
        for (int i = 0; i < 6; i++) begin
            busy   = VEC[i][7];
            open_b = VEC[i][6:3];
            #1;
            chk("R3 rf_req vector", int'(rf_req), int'(VEC[i][2]));
            chk("R7 pre_all vector", int'(pre_all), int'(VEC[i][1]));
            chk("R3 act_ok vector", int'(act_ok), int'(VEC[i][0]));
            step(1);
        end
        // R5 stray grant ignored
        busy = 1'b1; open_b = '0;
        gnt = 1'b1; step(1); gnt = 1'b0;
        chk("R5 stray grant debt", int'(debt), 1);
        // R5 / R6 real grant
        busy = 1'b0; #1;
        chk("R3 idle early request", int'(rf_req), 1);
        gnt = 1'b1; step(1); gnt = 1'b0;
        chk("R5 debt after grant", int'(debt), 0);
        chk("R6 act_ok in tRFC", int'(act_ok), 0);
        chk("R6 rd_ok in tRFC", int'(rd_ok), 0);
        step(RFC - 1);
        chk("R6 act_ok last tRFC cycle", int'(act_ok), 0);
        step(1);
        chk("R6 act_ok after tRFC", int'(act_ok), 1);
        // R4 / R11 fill the debt
        busy = 1'b1;
        step(MAXD * REFI + 4);
        chk("R4 debt full", int'(debt), MAXD);
        chk("R4 urgent", int'(urgent), 1);
        chk("R4 forced request while busy", int'(rf_req), 1);
        chk("R4 act_ok blocked", int'(act_ok), 0);
        chk("R4 rd_ok blocked", int'(rd_ok), 0);
        step(REFI + 2);
        chk("R11 saturated", int'(debt), MAXD);
        gnt = 1'b1; step(1); gnt = 1'b0;
        chk("R5 debt after forced grant", int'(debt), MAXD - 1);
        chk("R4 urgent clears", int'(urgent), 0);
        step(RFC + 1);
        chk("R3 deferred when busy", int'(rf_req), 0);
        // R8 entry with bank open, then closed
        open_b = 4'b0100; sr_req = 1'b1; #1;
        chk("R8 pre_all for entry", int'(pre_all), 1);
        step(1);
        chk("R8 cke held with open bank", int'(cke), 1);
        open_b = '0; step(1);
        chk("R8 cke low", int'(cke), 0);
        chk("R8 debt cleared", int'(debt), 0);
        // R9 long residency
        step(3 * REFI);
        chk("R9 debt stays zero", int'(debt), 0);
        chk("R9 no refresh request", int'(rf_req), 0);
        chk("R9 act_ok low", int'(act_ok), 0);
        // R10 exit guards
        sr_req = 1'b0; step(1);
        chk("R10 cke back", int'(cke), 1);
        chk("R10 act_ok guard start", int'(act_ok), 0);
        step(XSNR - 1);
        chk("R10 act_ok guard end", int'(act_ok), 0);
        step(1);
        chk("R10 act_ok released", int'(act_ok), 1);
        chk("R10 rd_ok still guarded", int'(rd_ok), 0);
        step(XSRD - XSNR - 1);
        chk("R10 rd_ok last guard cycle", int'(rd_ok), 0);
        step(1);
        chk("R10 rd_ok released", int'(rd_ok), 1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule